// File: doc/BRIEF.md
# Machine Trap and Return Controller

This block holds the machine-level trap state of a small 64-bit processor that runs at two privilege levels, user and machine. When the pipeline raises a synchronous exception, the block records the faulting PC, the cause code and a trap value. It pushes the interrupt-enable and privilege history in the status register, switches to machine level and hands the pipeline a redirect target taken from the trap vector register. When the pipeline executes a machine-mode return, the block pops that history, drops to the saved privilege and redirects to the saved exception PC.

Software reaches the trap vector, the exception PC and the status register through plain write ports. All register contents are visible on outputs. Every state change and every redirect is registered, so the results of a request appear in the cycle after the clock edge that accepts it.

Top module: `mtrap_unit`

## Requirements
- R1: After reset the privilege is machine (2'b11), the status, trap vector, exception PC, cause, trap value and redirect PC outputs are all zero, and redirectValid and intErr are low.
- R2: An accepted trap stores curPc into the exception PC and the 4-bit cause code, zero-extended, into the cause register. It sets the privilege to machine and presents the trap vector value from before the edge as redirectPc.
- R3: On an accepted trap, status bit 7 (saved enable) takes the old bit 3 (enable), bit 3 is cleared, and bits 12:11 (saved privilege) take the old privilege encoding: 2'b00 for user, 2'b11 for machine.
- R4: For cause codes 0, 1, 2, 4, 5, 6, 7, 12, 13 and 15 with faultValValid high, the trap value register takes faultVal.
- R5: For cause codes 8, 9 and 11 (environment calls) and the reserved codes 10 and 14, the trap value register becomes zero, whatever faultVal is.
- R6: For cause code 3 (breakpoint), the trap value register takes curPc.
- R7: A cause from the R4 list that arrives with faultValValid low still takes the trap in every other respect. It leaves the trap value register unchanged and raises intErr for exactly one cycle.
- R8: An accepted return sets status bit 3 from bit 7, sets bit 7 to 1, moves bits 12:11 into the privilege, clears bits 12:11 to 2'b00 and presents the exception PC value from before the edge as redirectPc.
- R9: When trapReq and retReq are both high, only the trap is performed.
- R10: redirectValid is high for exactly one cycle, in the cycle after each accepted request, and low after any cycle without a request. redirectPc holds its last value between requests.
- R11: A status write keeps only bit 3, bit 7 and bits 12:11, and all other status bits read as zero. A bits 12:11 value other than 2'b11 is stored as 2'b00. Trap vector and exception PC writes store the full value.
- R12: A software write in the same cycle as an accepted request reaches only the registers that the request does not update. A trap overrides status and exception PC writes, and a return overrides status writes. The redirect always uses register values from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | Take a synchronous exception this cycle |
| trapCause | input | 4 | Cause code of the exception |
| faultVal | input | 64 | Faulting address or instruction bits |
| faultValValid | input | 1 | faultVal carries a real value |
| retReq | input | 1 | Perform a machine-mode return this cycle |
| curPc | input | 64 | PC of the instruction that traps |
| tvecWrEn | input | 1 | Write strobe for the trap vector |
| tvecWrData | input | 64 | Trap vector write data |
| epcWrEn | input | 1 | Write strobe for the exception PC |
| epcWrData | input | 64 | Exception PC write data |
| statusWrEn | input | 1 | Write strobe for the status register |
| statusWrData | input | 64 | Status write data |
| redirectValid | output | 1 | One-cycle pulse: fetch from redirectPc |
| redirectPc | output | 64 | Redirect target |
| privMode | output | 2 | Current privilege, 2'b00 user, 2'b11 machine |
| statusOut | output | 64 | Status register |
| tvecOut | output | 64 | Trap vector register |
| epcOut | output | 64 | Exception PC register |
| causeOut | output | 64 | Cause register |
| tvalOut | output | 64 | Trap value register |
| intErr | output | 1 | Pulse: fault cause arrived without a value |

## Verification
The hardest state to reach is a trap taken from user level. The block leaves reset at machine level, and the only way down is a return with bits 12:11 at 2'b00. The stimulus therefore first writes the status register with bits 12:11 = 2'b00 and a set saved-enable bit, then issues a return, and only then drives faults, breakpoints and the missing-value error from user level. This checks that the saved privilege records 2'b00. Requests that collide with software writes, and trap and return together, are driven in single cycles, and a behavioural model checks every output on every clock.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
  localparam int CAUSE_W = 4;
  localparam logic [1:0] PRIV_USER = 2'b00;
  localparam logic [1:0] PRIV_MACH = 2'b11;
  localparam int EN_BIT = 3;
  localparam int SAVED_EN_BIT = 7;
  localparam int SAVED_PRIV_LO = 11;
  localparam int SAVED_PRIV_HI = 12;

  typedef enum logic [1:0] {
    TVAL_KEEP,
    TVAL_FAULT,
    TVAL_PC,
    TVAL_ZERO
  } tvalSel_e;

  typedef struct packed {
    logic     takeTrap;
    logic     takeRet;
    tvalSel_e tvalSel;
    logic     raiseErr;
  } ctlStrobe_t;
endpackage

// File: rtl/mtrap_ctrl.sv
module mtrap_ctrl
  import mtrap_pkg::*;
(
  input  logic               trapReq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic               faultValValid,
  input  logic               retReq,
  output ctlStrobe_t         strobe
);
  localparam int NUM_CODES = 1 << CAUSE_W;
  // causes that carry a faulting value
  localparam logic [NUM_CODES-1:0] VALUE_CAUSES = 16'b1011_0000_1111_0111;
  localparam logic [CAUSE_W-1:0] BREAK_CAUSE = 4'd3;

  logic valueCause;
  logic breakCause;

  assign valueCause = VALUE_CAUSES[trapCause];
  assign breakCause = (trapCause == BREAK_CAUSE);

  always_comb begin
    strobe          = '0;
    strobe.tvalSel  = TVAL_KEEP;
    strobe.takeTrap = trapReq;
    strobe.takeRet  = retReq && !trapReq;
    if (trapReq) begin
      if (breakCause) begin
        strobe.tvalSel = TVAL_PC;
      end else if (valueCause) begin
        if (faultValValid) begin
          strobe.tvalSel = TVAL_FAULT;
        end else begin
          strobe.tvalSel  = TVAL_KEEP;
          strobe.raiseErr = 1'b1;
        end
      end else begin
        strobe.tvalSel = TVAL_ZERO;
      end
    end
  end
endmodule

// File: rtl/mtrap_dpath.sv
module mtrap_dpath
  import mtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    faultVal,
  input  logic [XLEN-1:0]    curPc,
  input  logic               tvecWrEn,
  input  logic [XLEN-1:0]    tvecWrData,
  input  logic               epcWrEn,
  input  logic [XLEN-1:0]    epcWrData,
  input  logic               statusWrEn,
  input  logic [XLEN-1:0]    statusWrData,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic [1:0]         privMode,
  output logic [XLEN-1:0]    statusOut,
  output logic [XLEN-1:0]    tvecOut,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    tvalOut,
  output logic               intErr
);
  logic            enBit;
  logic            savedEn;
  logic [1:0]      savedPriv;
  logic [1:0]      privReg;
  logic [XLEN-1:0] tvecReg;
  logic [XLEN-1:0] epcReg;
  logic [XLEN-1:0] causeReg;
  logic [XLEN-1:0] tvalReg;
  logic [XLEN-1:0] redirReg;
  logic            redirValidReg;
  logic            errReg;
  logic [1:0]      wrPriv;
  logic            unusedStatusBits;

  assign wrPriv = (statusWrData[SAVED_PRIV_HI:SAVED_PRIV_LO] == PRIV_MACH) ? PRIV_MACH : PRIV_USER;
  assign unusedStatusBits = ^{statusWrData[XLEN-1:SAVED_PRIV_HI+1],
                              statusWrData[SAVED_PRIV_LO-1:SAVED_EN_BIT+1],
                              statusWrData[SAVED_EN_BIT-1:EN_BIT+1],
                              statusWrData[EN_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit         <= 1'b0;
      savedEn       <= 1'b0;
      savedPriv     <= PRIV_USER;
      privReg       <= PRIV_MACH;
      tvecReg       <= '0;
      epcReg        <= '0;
      causeReg      <= '0;
      tvalReg       <= '0;
      redirReg      <= '0;
      redirValidReg <= 1'b0;
      errReg        <= 1'b0;
    end else begin
      redirValidReg <= strobe.takeTrap | strobe.takeRet;
      errReg        <= strobe.raiseErr;
      if (tvecWrEn) begin
        tvecReg <= tvecWrData;
      end
      if (strobe.takeTrap) begin
        epcReg    <= curPc;
        causeReg  <= {{(XLEN-CAUSE_W){1'b0}}, trapCause};
        savedEn   <= enBit;
        enBit     <= 1'b0;
        savedPriv <= privReg;
        privReg   <= PRIV_MACH;
        redirReg  <= tvecReg;
        unique case (strobe.tvalSel)
          TVAL_FAULT: tvalReg <= faultVal;
          TVAL_PC:    tvalReg <= curPc;
          TVAL_ZERO:  tvalReg <= '0;
          default:    tvalReg <= tvalReg;
        endcase
      end else if (strobe.takeRet) begin
        enBit     <= savedEn;
        savedEn   <= 1'b1;
        privReg   <= savedPriv;
        savedPriv <= PRIV_USER;
        redirReg  <= epcReg;
        if (epcWrEn) begin
          epcReg <= epcWrData;
        end
      end else begin
        if (epcWrEn) begin
          epcReg <= epcWrData;
        end
        if (statusWrEn) begin
          enBit     <= statusWrData[EN_BIT];
          savedEn   <= statusWrData[SAVED_EN_BIT];
          savedPriv <= wrPriv;
        end
      end
    end
  end

  always_comb begin
    statusOut                              = '0;
    statusOut[EN_BIT]                      = enBit;
    statusOut[SAVED_EN_BIT]                = savedEn;
    statusOut[SAVED_PRIV_HI:SAVED_PRIV_LO] = savedPriv;
  end

  assign redirectValid = redirValidReg;
  assign redirectPc    = redirReg;
  assign privMode      = privReg;
  assign tvecOut       = tvecReg;
  assign epcOut        = epcReg;
  assign causeOut      = causeReg;
  assign tvalOut       = tvalReg;
  assign intErr        = errReg;
endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapReq,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    faultVal,
  input  logic               faultValValid,
  input  logic               retReq,
  input  logic [XLEN-1:0]    curPc,
  input  logic               tvecWrEn,
  input  logic [XLEN-1:0]    tvecWrData,
  input  logic               epcWrEn,
  input  logic [XLEN-1:0]    epcWrData,
  input  logic               statusWrEn,
  input  logic [XLEN-1:0]    statusWrData,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic [1:0]         privMode,
  output logic [XLEN-1:0]    statusOut,
  output logic [XLEN-1:0]    tvecOut,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    causeOut,
  output logic [XLEN-1:0]    tvalOut,
  output logic               intErr
);
  ctlStrobe_t strobe;

  mtrap_ctrl ctrl_i (
    .trapReq       (trapReq),
    .trapCause     (trapCause),
    .faultValValid (faultValValid),
    .retReq        (retReq),
    .strobe        (strobe)
  );

  mtrap_dpath #(.XLEN(XLEN)) dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .trapCause     (trapCause),
    .faultVal      (faultVal),
    .curPc         (curPc),
    .tvecWrEn      (tvecWrEn),
    .tvecWrData    (tvecWrData),
    .epcWrEn       (epcWrEn),
    .epcWrData     (epcWrData),
    .statusWrEn    (statusWrEn),
    .statusWrData  (statusWrData),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .privMode      (privMode),
    .statusOut     (statusOut),
    .tvecOut       (tvecOut),
    .epcOut        (epcOut),
    .causeOut      (causeOut),
    .tvalOut       (tvalOut),
    .intErr        (intErr)
  );
endmodule

// File: rtl/mtrap_unit_chk.sv
module mtrap_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapReq,
  input logic [3:0]      trapCause,
  input logic            retReq,
  input logic [XLEN-1:0] curPc,
  input logic            redirectValid,
  input logic [XLEN-1:0] redirectPc,
  input logic [1:0]      privMode,
  input logic [XLEN-1:0] statusOut,
  input logic [XLEN-1:0] tvecOut,
  input logic [XLEN-1:0] epcOut,
  input logic [XLEN-1:0] tvalOut,
  input logic            intErr
);
  p_trap_machine_r2: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> redirectValid && privMode == 2'b11 && epcOut == $past(curPc));

  p_trap_stack_r3: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> !statusOut[3] && statusOut[7] == $past(statusOut[3])
                && statusOut[12:11] == $past(privMode));

  p_ecall_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && (trapCause == 4'd8 || trapCause == 4'd9 || trapCause == 4'd11) |=> tvalOut == '0);

  p_break_pc_r6: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && trapCause == 4'd3 |=> tvalOut == $past(curPc));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    intErr |-> tvalOut == $past(tvalOut));

  p_return_r8: assert property (@(posedge clk) disable iff (!rstN)
    retReq && !trapReq |=> redirectPc == $past(epcOut) && statusOut[7]
                           && statusOut[12:11] == 2'b00 && privMode == $past(statusOut[12:11]));

  p_trap_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    trapReq && retReq |=> privMode == 2'b11 && redirectPc == $past(tvecOut));

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq || retReq) |=> !redirectValid);

  p_legal_priv_r11: assert property (@(posedge clk) disable iff (!rstN)
    (privMode == 2'b00 || privMode == 2'b11)
    && (statusOut[12:11] == 2'b00 || statusOut[12:11] == 2'b11));
endmodule

bind mtrap_unit mtrap_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .trapReq       (trapReq),
  .trapCause     (trapCause),
  .retReq        (retReq),
  .curPc         (curPc),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .privMode      (privMode),
  .statusOut     (statusOut),
  .tvecOut       (tvecOut),
  .epcOut        (epcOut),
  .tvalOut       (tvalOut),
  .intErr        (intErr)
);

// File: tb/mtrap_unit_tb_top.sv
`timescale 1ns/1ps
module mtrap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [3:0]  trapCause = '0;
  logic [63:0] faultVal = '0;
  logic        faultValValid = 1'b0;
  logic        retReq = 1'b0;
  logic [63:0] curPc = '0;
  logic        tvecWrEn = 1'b0;
  logic [63:0] tvecWrData = '0;
  logic        epcWrEn = 1'b0;
  logic [63:0] epcWrData = '0;
  logic        statusWrEn = 1'b0;
  logic [63:0] statusWrData = '0;
  logic        redirectValid;
  logic [63:0] redirectPc;
  logic [1:0]  privMode;
  logic [63:0] statusOut, tvecOut, epcOut, causeOut, tvalOut;
  logic        intErr;

  int checks = 0;
  int failures = 0;

  // reference model state (expected outputs)
  logic        eEn, eSavedEn, eRv, eErr;
  logic [1:0]  eSavedPriv, ePriv;
  logic [63:0] eTvec, eEpc, eCause, eTval, eRpc;

  always #4 clk = ~clk;

  mtrap_unit dut_i (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapCause(trapCause),
    .faultVal(faultVal), .faultValValid(faultValValid), .retReq(retReq),
    .curPc(curPc), .tvecWrEn(tvecWrEn), .tvecWrData(tvecWrData),
    .epcWrEn(epcWrEn), .epcWrData(epcWrData), .statusWrEn(statusWrEn),
    .statusWrData(statusWrData), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .privMode(privMode), .statusOut(statusOut),
    .tvecOut(tvecOut), .epcOut(epcOut), .causeOut(causeOut),
    .tvalOut(tvalOut), .intErr(intErr)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    logic [63:0] st;
    st = '0;
    st[3] = eEn;
    st[7] = eSavedEn;
    st[12:11] = eSavedPriv;
    chk(tag, "redirectValid", {63'd0, redirectValid}, {63'd0, eRv});
    chk(tag, "redirectPc", redirectPc, eRpc);
    chk(tag, "privMode", {62'd0, privMode}, {62'd0, ePriv});
    chk(tag, "status", statusOut, st);
    chk(tag, "tvec", tvecOut, eTvec);
    chk(tag, "epc", epcOut, eEpc);
    chk(tag, "cause", causeOut, eCause);
    chk(tag, "tval", tvalOut, eTval);
    chk(tag, "intErr", {63'd0, intErr}, {63'd0, eErr});
  endtask

  function automatic bit carriesValue(logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd15: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // apply current inputs for one clock, advance model, compare
  task automatic step(string tag);
    logic nEn, nSavedEn, nRv, nErr;
    logic [1:0] nSavedPriv, nPriv;
    logic [63:0] nTvec, nEpc, nCause, nTval, nRpc;
    nEn = eEn; nSavedEn = eSavedEn; nSavedPriv = eSavedPriv; nPriv = ePriv;
    nTvec = eTvec; nEpc = eEpc; nCause = eCause; nTval = eTval; nRpc = eRpc;
    nRv = trapReq || retReq;
    nErr = 1'b0;
    if (tvecWrEn) nTvec = tvecWrData;
    if (trapReq) begin
      nEpc = curPc;
      nCause = {60'd0, trapCause};
      nSavedEn = eEn;
      nEn = 1'b0;
      nSavedPriv = ePriv;
      nPriv = 2'b11;
      nRpc = eTvec;
      if (trapCause == 4'd3) nTval = curPc;
      else if (carriesValue(trapCause)) begin
        if (faultValValid) nTval = faultVal;
        else nErr = 1'b1;
      end else nTval = '0;
    end else if (retReq) begin
      nEn = eSavedEn;
      nSavedEn = 1'b1;
      nPriv = eSavedPriv;
      nSavedPriv = 2'b00;
      nRpc = eEpc;
      if (epcWrEn) nEpc = epcWrData;
    end else begin
      if (epcWrEn) nEpc = epcWrData;
      if (statusWrEn) begin
        nEn = statusWrData[3];
        nSavedEn = statusWrData[7];
        nSavedPriv = (statusWrData[12:11] == 2'b11) ? 2'b11 : 2'b00;
      end
    end
    @(posedge clk);
    @(negedge clk);
    eEn = nEn; eSavedEn = nSavedEn; eSavedPriv = nSavedPriv; ePriv = nPriv;
    eTvec = nTvec; eEpc = nEpc; eCause = nCause; eTval = nTval; eRpc = nRpc;
    eRv = nRv; eErr = nErr;
    compareAll(tag);
    trapReq = 0; retReq = 0; faultValValid = 0; tvecWrEn = 0; epcWrEn = 0; statusWrEn = 0;
  endtask

  task automatic doTrap(logic [3:0] c, logic [63:0] pc, logic [63:0] fv, logic fvOk, string tag);
    trapReq = 1; trapCause = c; curPc = pc; faultVal = fv; faultValValid = fvOk;
    step(tag);
  endtask

  task automatic doRet(string tag);
    retReq = 1;
    step(tag);
  endtask

  task automatic wrStatus(logic [63:0] d, string tag);
    statusWrEn = 1; statusWrData = d;
    step(tag);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    eEn = 0; eSavedEn = 0; eSavedPriv = 2'b00; ePriv = 2'b11;
    eTvec = '0; eEpc = '0; eCause = '0; eTval = '0; eRpc = '0; eRv = 0; eErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    compareAll("R1");

    // R11: writes, masking and legalization of bits 12:11
    tvecWrEn = 1; tvecWrData = 64'h0000_0000_8000_0100;
    epcWrEn = 1; epcWrData = 64'h0000_0000_0000_4444;
    step("R11");
    wrStatus(64'hFFFF_FFFF_FFFF_EFFF, "R11");  // bits 12:11 = 01 -> stored 00
    wrStatus(64'h0000_0000_0000_1808, "R11");  // MIE=1, MPP=11

    // R2 R3 R5: ecall from machine level
    doTrap(4'd11, 64'h1000, 64'hDEAD, 1, "R5");
    step("R10");                                 // idle cycle: no pulse
    doRet("R8");                                 // back to machine
    // go to user: saved priv 00, saved enable 1
    wrStatus(64'h0000_0000_0000_0080, "R11");
    doRet("R8");
    // R3: trap from user level records 00
    doTrap(4'd5, 64'h2000, 64'h0000_0000_ABCD_0008, 1, "R4");
    doRet("R8");
    doTrap(4'd3, 64'h2468, 64'h5555, 1, "R6");
    doRet("R8");
    doTrap(4'd13, 64'h3000, 64'h9999, 0, "R7");
    step("R7");                                  // intErr gone
    doTrap(4'd10, 64'h3004, 64'h7777, 1, "R5");
    doTrap(4'd14, 64'h3008, 64'h7777, 1, "R5");

    // sweep all codes with and without a valid value
    for (int c = 0; c < 16; c++) begin
      doTrap(c[3:0], 64'h4000 + 64'(c * 4), 64'hF000_0000 + 64'(c), 1, "R4");
      doTrap(c[3:0], 64'h5000 + 64'(c * 4), 64'hE000_0000 + 64'(c), c[0], "R7");
    end

    // R9: simultaneous trap and return
    wrStatus(64'h0000_0000_0000_0008, "R11");
    trapReq = 1; retReq = 1; trapCause = 4'd2; curPc = 64'h6000;
    faultVal = 64'h1234; faultValValid = 1;
    step("R9");

    // R12: trap with concurrent writes
    trapReq = 1; trapCause = 4'd8; curPc = 64'h7000;
    tvecWrEn = 1; tvecWrData = 64'h0000_0000_8000_0200;
    epcWrEn = 1; epcWrData = 64'hBBBB;
    statusWrEn = 1; statusWrData = 64'h0000_0000_0000_0088;
    step("R12");
    // R12: return with concurrent epc and status writes
    retReq = 1; epcWrEn = 1; epcWrData = 64'hCCCC;
    statusWrEn = 1; statusWrData = 64'h0000_0000_0000_1808;
    step("R12");
    doRet("R12");                                // redirects to CCCC
    repeat (2) step("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule